// File: doc/BRIEF.md
# Sliding-Window Rank-Order Selector

This block watches a stream of 16-bit unsigned samples and reports the 24th smallest value among the 32 most recent accepted samples. The result is refreshed on every clock that carries a sample. A typical use is as the ranking stage in front of an order-statistic threshold detector. The block keeps its 32 entries sorted in a register array. Each accepted sample is placed into the array in one clock, and the oldest entry is removed in the same clock.

Placement uses one comparator per stored entry. Each comparator reports whether its stored value is less than or equal to the incoming value. Taken over the sorted array, these flags form a thermometer code, and the number of ones in it is the insertion index. Every entry then holds its slot or moves one slot towards the gap left by the removed entry.

Each entry carries an age tag. The entry whose age reaches 31 is the one removed. Right after reset the array holds filler entries, each flagged as invalid. Fillers always sort above real samples, and they leave from the top end of the array.

Top module: `rws_rank_select`

## Requirements
- R1: Synchronous active-low reset. After reset, `win_full` and `rank_valid` are 0 and `rank_data` is 0xFFFF.
- R2: After the 32nd accepted sample, `rank_data` equals the 24th smallest value (1-based, ascending) of the last 32 accepted samples. The value is updated at the same clock edge that accepts the sample.
- R3: Equal values, including real samples of 0xFFFF, are ranked correctly. A new sample is placed above all stored entries of the same value.
- R4: `win_full` and `rank_valid` rise at the edge that accepts the 32nd sample after reset. They stay high until the next reset, and the two flags are always equal.
- R5: While `smp_valid` is low, the window does not change. `rank_data` and `win_full` hold their values, and later results are computed as if those cycles had not occurred.
- R6: While fewer than 32 samples have been accepted, the fillers leave from the top end. With k real samples accepted, `rank_data` is the 24th smallest of them when k ≥ 24, and 0xFFFF otherwise.
- R7: At every clock the stored array is ascending, all real entries sit below all filler entries, and each accepted sample during filling adds exactly one real entry.
- R8: A reset in the middle of a stream empties the window. The following samples are ranked with no trace of the samples that came before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe; high accepts `smp_data` at this edge |
| smp_data | input | 16 | Unsigned sample value |
| rank_data | output | 16 | 24th smallest value of the current window |
| rank_valid | output | 1 | High once 32 samples are in the window |
| win_full | output | 1 | Window holds 32 real samples |

## Verification
An error in the stored order, in the ages or in the choice of removal slot does not always show at once. It appears as a wrong `rank_data` once the damaged entry crosses rank 24, or 32 accepted samples later when the wrong entry leaves in place of the oldest one. For this reason every accepted sample is checked against a full re-sort of the last 32 samples. This check runs over long random runs and over runs of repeated values, so delayed errors are caught within one window length. Errors in the filling phase show within the first 32 samples: a filler crossing rank 24 out of turn, or a flag rising one sample early or late.

// File: rtl/rws_pkg.sv
`timescale 1ns/1ps
// Package: shared default sizes for the rank selector.
// Assumes: unsigned samples; rank counted 1-based from the smallest value.
package rws_pkg;
    localparam int SMP_W_DEF = 16;
    localparam int WIN_N_DEF = 32;
    localparam int RANK_DEF  = 24;
endpackage

// File: rtl/rws_cmp_bank.sv
`timescale 1ns/1ps
// Module: rws_cmp_bank
// Compares the incoming sample against every stored slot in parallel.
// le[i] is high when slot i holds a real value that is <= the new sample.
// Assumes: slots are sorted with real entries below fillers, so le is a
// thermometer code whose population is the insertion index.
module rws_cmp_bank #(
    parameter int N = 32,
    parameter int W = 16
) (
    input  logic [N-1:0]        slot_vld,
    input  logic [N-1:0][W-1:0] slot_val,
    input  logic [W-1:0]        new_val,
    output logic [N-1:0]        le
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // one comparator per slot; fillers never compare as <=
        assign le[i] = slot_vld[i] && (slot_val[i] <= new_val);
    end
endmodule

// File: rtl/rws_locate.sv
`timescale 1ns/1ps
// Module: rws_locate
// Turns the thermometer compare vector into an insertion index and picks
// the slot that departs on this update.
// Assumes: if any filler remains, the top slot is a filler; otherwise
// exactly one real slot carries age N-1.
module rws_locate #(
    parameter int N  = 32,
    parameter int AW = 5,
    parameter int IW = 5,
    parameter int PW = 6
) (
    input  logic [N-1:0]         le,
    input  logic [N-1:0]         slot_vld,
    input  logic [N-1:0][AW-1:0] slot_age,
    output logic [PW-1:0]        ins_pos,
    output logic [IW-1:0]        del_pos
);
    // insertion index = number of entries at or below the new value
    always_comb begin
        ins_pos = '0;
        for (int i = 0; i < N; i++) begin
            ins_pos = ins_pos + PW'(le[i]);
        end
    end

    // departing slot: top filler while filling, else the oldest entry
    always_comb begin
        del_pos = IW'(N - 1);
        if (slot_vld[N-1]) begin
            del_pos = '0;
            for (int i = 0; i < N; i++) begin
                if (slot_age[i] == AW'(N - 1)) del_pos = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rws_slot_array.sv
`timescale 1ns/1ps
// Module: rws_slot_array
// Sorted register array of {valid, age, value} slots. On an update each
// slot either holds, takes the new sample, or copies one neighbour, so the
// departing slot is closed and a gap opens at the insertion point.
// Assumes: ins_pos in 0..N, del_pos in 0..N-1, computed on the current state.
module rws_slot_array #(
    parameter int N  = 32,
    parameter int W  = 16,
    parameter int AW = 5,
    parameter int IW = 5,
    parameter int PW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [W-1:0]         new_val,
    input  logic [PW-1:0]        ins_pos,
    input  logic [IW-1:0]        del_pos,
    output logic [N-1:0]         slot_vld,
    output logic [N-1:0][AW-1:0] slot_age,
    output logic [N-1:0][W-1:0]  slot_val
);
    localparam int SW = 1 + AW + W;
    localparam logic [SW-1:0] FILL  = {1'b0, {AW{1'b0}}, {W{1'b1}}};

    logic [N-1:0][SW-1:0] slot_q;
    logic [SW-1:0]        new_ent;

    assign new_ent = {1'b1, {AW{1'b0}}, new_val};

    for (genvar j = 0; j < N; j++) begin : g_slot
        logic [SW-1:0] lower, upper, pick, nxt;
        logic          took_new;

        if (j == 0) begin : g_lo_edge
            assign lower = FILL;
        end else begin : g_lo
            assign lower = slot_q[j-1];
        end
        if (j == N - 1) begin : g_hi_edge
            assign upper = FILL;
        end else begin : g_hi
            assign upper = slot_q[j+1];
        end

        // choose hold, new sample, or a one-step neighbour move
        always_comb begin
            int p, d;
            p        = int'(ins_pos);
            d        = int'(del_pos);
            pick     = slot_q[j];
            took_new = 1'b0;
            if (p <= d) begin
                if (j == p) begin
                    pick     = new_ent;
                    took_new = 1'b1;
                end else if (j > p && j <= d) begin
                    pick = lower;
                end
            end else begin
                if (j == p - 1) begin
                    pick     = new_ent;
                    took_new = 1'b1;
                end else if (j >= d && j < p - 1) begin
                    pick = upper;
                end
            end
        end

        // age every surviving real entry by one
        always_comb begin
            nxt = pick;
            if (!took_new && pick[SW-1]) begin
                nxt[W+AW-1:W] = pick[W+AW-1:W] + AW'(1);
            end
        end

        // slot register with synchronous active-low reset to filler
        always_ff @(posedge clk) begin
            if (!rst_n)   slot_q[j] <= FILL;
            else if (upd) slot_q[j] <= nxt;
        end

        assign slot_vld[j] = slot_q[j][SW-1];
        assign slot_age[j] = slot_q[j][W+AW-1:W];
        assign slot_val[j] = slot_q[j][W-1:0];
    end
endmodule

// File: rtl/rws_rank_select.sv
`timescale 1ns/1ps
// Module: rws_rank_select (top)
// Running rank-order selector over a sliding window of the last WIN_N
// accepted samples; presents the RANK-th smallest value every clock.
// Assumes: 1 <= RANK <= WIN_N; one sample per clock at most.
module rws_rank_select
    import rws_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF,
    parameter int WIN_N = WIN_N_DEF,
    parameter int RANK  = RANK_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic [SMP_W-1:0] rank_data,
    output logic             rank_valid,
    output logic             win_full
);
    localparam int AW = $clog2(WIN_N);
    localparam int IW = $clog2(WIN_N);
    localparam int PW = $clog2(WIN_N + 1);

    logic [WIN_N-1:0]            slot_vld;
    logic [WIN_N-1:0][AW-1:0]    slot_age;
    logic [WIN_N-1:0][SMP_W-1:0] slot_val;
    logic [WIN_N-1:0]            le;
    logic [PW-1:0]               ins_pos;
    logic [IW-1:0]               del_pos;

    rws_cmp_bank #(.N(WIN_N), .W(SMP_W)) u_cmp (
        .slot_vld (slot_vld),
        .slot_val (slot_val),
        .new_val  (smp_data),
        .le       (le)
    );

    rws_locate #(.N(WIN_N), .AW(AW), .IW(IW), .PW(PW)) u_loc (
        .le       (le),
        .slot_vld (slot_vld),
        .slot_age (slot_age),
        .ins_pos  (ins_pos),
        .del_pos  (del_pos)
    );

    rws_slot_array #(.N(WIN_N), .W(SMP_W), .AW(AW), .IW(IW), .PW(PW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (smp_valid),
        .new_val  (smp_data),
        .ins_pos  (ins_pos),
        .del_pos  (del_pos),
        .slot_vld (slot_vld),
        .slot_age (slot_age),
        .slot_val (slot_val)
    );

    // outputs come straight from registered slots
    assign rank_data  = slot_val[RANK-1];
    assign win_full   = slot_vld[WIN_N-1];
    assign rank_valid = slot_vld[WIN_N-1];
endmodule

// File: rtl/rws_chk.sv
`timescale 1ns/1ps
// Module: rws_chk
// Property checker bound to rws_rank_select; observes ports and slot state.
// Assumes: reset held low for at least two clock edges at start.
module rws_chk #(
    parameter int N = 32,
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [W-1:0]        rank_data,
    input logic                rank_valid,
    input logic                win_full,
    input logic [N-1:0]        slot_vld,
    input logic [N-1:0][W-1:0] slot_val
);
    logic order_ok;

    // scan neighbours for ordering and filler placement
    always_comb begin
        order_ok = 1'b1;
        for (int j = 0; j < N - 1; j++) begin
            if (slot_vld[j+1] && !slot_vld[j]) order_ok = 1'b0;
            if (slot_vld[j+1] && slot_vld[j] && (slot_val[j] > slot_val[j+1]))
                order_ok = 1'b0;
        end
    end

    // R7
    sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_ok);

    // R7
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !win_full) |=>
            ($countones(slot_vld) == $past($countones(slot_vld)) + 1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(rank_data) && $stable(win_full)));

    // R4
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_full |=> win_full);

    // R4
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rank_valid == win_full);
endmodule

bind rws_rank_select rws_chk #(.N(WIN_N), .W(SMP_W)) u_rws_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .rank_data  (rank_data),
    .rank_valid (rank_valid),
    .win_full   (win_full),
    .slot_vld   (slot_vld),
    .slot_val   (slot_val)
);

// File: tb/test_rws_rank_select.sv
`timescale 1ns/1ps
module test_rws_rank_select;
    localparam int N  = 32;
    localparam int W  = 16;
    localparam int RK = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic [W-1:0] rank_data;
    logic         rank_valid;
    logic         win_full;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_buf [N];
    int           m_cnt = 0;

    always #2 clk = ~clk;

    rws_rank_select i_rws_rank_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .rank_data  (rank_data),
        .rank_valid (rank_valid),
        .win_full   (win_full)
    );

    function automatic logic [W-1:0] exp_rank();
        logic [W-1:0] t [N];
        logic [W-1:0] k;
        int           p;
        if (m_cnt < RK) return {W{1'b1}};
        for (int i = 0; i < m_cnt; i++) t[i] = m_buf[i];
        for (int i = 1; i < m_cnt; i++) begin
            k = t[i];
            p = i - 1;
            while (p >= 0 && t[p] > k) begin
                t[p+1] = t[p];
                p--;
            end
            t[p+1] = k;
        end
        return t[RK-1];
    endfunction

    task automatic model_push(input logic [W-1:0] d);
        if (m_cnt < N) begin
            m_buf[m_cnt] = d;
            m_cnt++;
        end else begin
            for (int i = 0; i < N - 1; i++) m_buf[i] = m_buf[i+1];
            m_buf[N-1] = d;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        chk({req, " rank"}, int'(rank_data), int'(exp_rank()));
        chk({req, " full"}, int'(win_full), int'(m_cnt == N));
        chk({req, " valid"}, int'(rank_valid), int'(m_cnt == N));
    endtask

    task automatic step(input bit v, input logic [W-1:0] d);
        @(negedge clk);
        smp_valid = v;
        smp_data  = d;
        @(posedge clk);
        if (v) model_push(d);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
    endtask

    // R1: reset state at the ports
    task automatic t_reset();
        do_reset();
        chk("R1 rank", int'(rank_data), 16'hFFFF);
        chk("R1 full", int'(win_full), 0);
        chk("R1 valid", int'(rank_valid), 0);
    endtask

    // R6 / R4: filling phase, fillers leave from the top end
    task automatic t_fill();
        for (int i = 0; i < N; i++) begin
            step(1'b1, W'($urandom_range(0, 65535)));
            chk_model("R6");
        end
        chk("R4 full after 32", int'(win_full), 1);
    endtask

    // R2: long random stream
    task automatic t_stream();
        for (int i = 0; i < 300; i++) begin
            step(1'b1, W'($urandom_range(0, 65535)));
            chk_model("R2");
        end
    endtask

    // R3: runs of duplicates, including real 0xFFFF samples
    task automatic t_dups();
        logic [W-1:0] v;
        for (int r = 0; r < 40; r++) begin
            case ($urandom_range(0, 3))
                0: v = 16'h0000;
                1: v = 16'h0005;
                2: v = 16'hFFFF;
                default: v = W'($urandom_range(0, 7));
            endcase
            for (int k = 0; k < int'($urandom_range(1, 9)); k++) begin
                step(1'b1, v);
                chk_model("R3");
            end
        end
    endtask

    // R5: idle cycles leave outputs and window untouched
    task automatic t_hold();
        logic [W-1:0] prev_r;
        logic         prev_f;
        for (int i = 0; i < 150; i++) begin
            bit v;
            v      = ($urandom_range(0, 2) == 0) ? 1'b0 : 1'b1;
            prev_r = rank_data;
            prev_f = win_full;
            step(v, W'($urandom_range(0, 65535)));
            if (!v) begin
                chk("R5 rank hold", int'(rank_data), int'(prev_r));
                chk("R5 full hold", int'(win_full), int'(prev_f));
            end
            chk_model("R5");
        end
    endtask

    // R8: reset mid-stream empties the window
    task automatic t_midreset();
        for (int i = 0; i < 10; i++) step(1'b1, 16'h0001);
        do_reset();
        chk("R8 rank", int'(rank_data), 16'hFFFF);
        chk("R8 full", int'(win_full), 0);
        for (int i = 0; i < 40; i++) begin
            step(1'b1, W'($urandom_range(100, 900)));
            chk_model("R8");
        end
    endtask

    initial begin
        t_reset();
        t_fill();
        t_stream();
        t_dups();
        t_hold();
        t_midreset();
        t_reset();
        t_dups();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule